// File: doc/BRIEF.md
# Low-Frequency Reader Clock Generator and Sample Serializer

The block turns one main clock into every timing signal a low-frequency reader front end needs: a serial bit clock, a coil-drive clock and an ADC sample clock, all cut from a single divider chain. Because the chain is shared, one coil period always holds exactly eight bit periods. Each bit period carries one bit of an ADC sample, so one coil period carries exactly one serialized 8-bit sample.

A select input picks one of two fixed carrier rates. A program-enable input switches the chain to a rate taken from an 8-bit divisor, which is clamped to a bounded range. The sample is captured when the ADC clock rises in mid-frame. It is then shifted out most significant bit first during the next frame. A frame output marks the frames that carry data. A debug output repeats the ADC clock. The unused power and enable outputs are held low. A rate change waits for the next frame boundary, so no bit period is ever cut short.

Top module: `lf_clock_serializer`

## Requirements
- R1: With `prog_en`=0, `bit_clk` stays in each level for 11+`rate_sel` main clocks, which is 12 for `rate_sel`=1 and 11 for `rate_sel`=0. After reset it starts low, and its first rise comes at the end of the first half period.
- R2: A frame is 8 bit periods long. Bit slots are numbered 0 to 7 and each slot starts at a falling edge of `bit_clk`. `coil_clk` is high in slots 0-3 and low in slots 4-7, so its period is 8 bit periods.
- R3: `adc_clk` is low in slots 0-3 and high in slots 4-7. `debug_clk` always equals `adc_clk`.
- R4: `frame` is low for the first frame after reset and goes high at the first frame boundary. It then stays high while frames are shifted.
- R5: In every frame after the first, slot b of `ser_data` holds bit 7-b of the `adc_data` value that was sampled when `adc_clk` rose in the previous frame. `ser_data` changes only on a falling edge of `bit_clk`, and it is 0 before the first frame boundary.
- R6: `hf_pwr` and all bits of `pwr_en` are held at 0.
- R7: With `prog_en`=1, the half period of `bit_clk` is (D+1)>>3 main clocks. D is `prog_div` clamped to the range 16 to 255. A value of 95 therefore gives 12, the same as the fixed 125 kHz rate, and any value below 16 behaves like 16 (half period 2).
- R8: Changes on `rate_sel`, `prog_en` and `prog_div` take effect only at a frame boundary. The rate for the next frame is taken from the input values at the edge that ends the current frame.
- R9: When `rst_n` is 0 at a clock edge, the block resets synchronously. After that edge `bit_clk`=0, `coil_clk`=1, `adc_clk`=0, `frame`=0, `ser_data`=0, and the rate is loaded from the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 1 | Fixed carrier rate select (1: divide by 24, 0: divide by 22) |
| prog_en | input | 1 | Use the programmable divisor instead of `rate_sel` |
| prog_div | input | 8 | Programmable divisor, clamped to 16..255 |
| adc_data | input | 8 | ADC sample value |
| bit_clk | output | 1 | Serial bit clock |
| coil_clk | output | 1 | Coil-drive clock, bit clock divided by 8 |
| adc_clk | output | 1 | ADC sample clock, same rate as the coil clock |
| debug_clk | output | 1 | Copy of `adc_clk` |
| frame | output | 1 | High while sample bits are being shifted |
| ser_data | output | 1 | Serial sample data, MSB first |
| hf_pwr | output | 1 | Unused high-frequency power drive, held low |
| pwr_en | output | 4 | Unused enable outputs, held low |

## Verification
Every output comes straight from a register, so it takes its new value on the main-clock edge where the divider count ends. The first `bit_clk` rise comes h edges after reset is released, and slot, frame and data changes come at multiples of 2h edges. A sample taken at edge 8h of one frame appears on `ser_data` from edge 16h, the start of the next frame. The bench counts edges since the last reset, works out each expected level from that count and the half period in force for the frame, and compares at the falling clock edge just after each rising edge. When an input changes mid-frame, the bench keeps the old half period until it reaches its own computed frame boundary, so the rule that a rate change waits for the boundary is checked on every cycle.

// File: rtl/lfr_pkg.sv
// Package: shared helpers for the low-frequency reader clock block.
// Assumes the divisor to half-period mapping is a right shift of (D+1).
package lfr_pkg;

    // Clamp a divisor to [dmin, dmax] and map it to a bit half period.
    function automatic int prog_half(input int div, input int dmin,
                                     input int dmax, input int shift);
        int d;
        d = div;
        if (d < dmin) d = dmin;
        if (d > dmax) d = dmax;
        return (d + 1) >> shift;
    endfunction

    // Larger of two integers, used for width sizing.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Smaller of two integers, used for range checks.
    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/lfr_rate_sel.sv
// Module: lfr_rate_sel
// Holds the bit half period, in main clocks, that is in force for the current frame.
// It reloads from the select or divisor inputs only in reset or at a frame end.
// Assumes frame_end is a single-cycle pulse that comes at a bit-clock fall.
module lfr_rate_sel
    import lfr_pkg::*;
#(
    parameter int FIXED_BASE = 11,
    parameter int DIV_W      = 8,
    parameter int DIV_MIN    = 16,
    parameter int DIV_MAX    = 255,
    parameter int DIV_SHIFT  = 3,
    parameter int HALF_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic              rate_sel,
    input  logic              prog_en,
    input  logic [DIV_W-1:0]  prog_div,
    output logic [HALF_W-1:0] half
);
    localparam int HALF_MIN = imin(FIXED_BASE, (DIV_MIN + 1) >> DIV_SHIFT);
    localparam int HALF_MAX = imax(FIXED_BASE + 1, (DIV_MAX + 1) >> DIV_SHIFT);

    logic [HALF_W-1:0] half_next;

    // Work out the half period the inputs ask for.
    always_comb begin
        if (prog_en)
            half_next = HALF_W'(prog_half(int'(prog_div), DIV_MIN, DIV_MAX, DIV_SHIFT));
        else
            half_next = HALF_W'(FIXED_BASE + int'(rate_sel));
    end

    // Load the half period in reset or at a frame boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_end)
            half <= half_next;
    end

    // R7: the held half period stays inside the range the clamp allows.
    p_half_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(half) >= HALF_MIN) && (int'(half) <= HALF_MAX));

    // R8: the half period changes only after a frame boundary.
    p_half_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_end) |-> $stable(half));

endmodule

// File: rtl/lfr_bit_divider.sv
// Module: lfr_bit_divider
// Divides the main clock down to the serial bit clock. Each level lasts half main clocks.
// Gives a one-cycle pulse on the edge where bit_clk falls, which starts a bit slot.
// Assumes half >= 2 and that half changes only on a fall, when the count restarts.
module lfr_bit_divider #(
    parameter int HALF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] half,
    output logic              bit_clk,
    output logic              bit_fall
);
    logic [HALF_W-1:0] cnt;
    logic              tick;

    assign tick     = (cnt == half - HALF_W'(1));
    assign bit_fall = tick && bit_clk;

    // Count main clocks and toggle the bit clock at the end of each half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_clk <= 1'b0;
        end else if (tick) begin
            cnt     <= '0;
            bit_clk <= ~bit_clk;
        end else begin
            cnt <= cnt + HALF_W'(1);
        end
    end

    // R1: the count never runs past the half period in force.
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < half);

endmodule

// File: rtl/lfr_frame_seq.sv
// Module: lfr_frame_seq
// Keeps track of the bit slot within a frame. Drives the coil and ADC clocks from the slot,
// captures the sample when the ADC clock rises and shifts it out MSB first in the next frame.
// Assumes bit_fall is a single-cycle pulse per bit period.
module lfr_frame_seq #(
    parameter int DATA_W = 8,
    parameter int BIT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_fall,
    input  logic              bit_clk,
    input  logic [DATA_W-1:0] adc_data,
    output logic              frame_end,
    output logic              coil_clk,
    output logic              adc_clk,
    output logic              frame,
    output logic              ser_data
);
    localparam logic [BIT_W-1:0] LAST_SLOT = BIT_W'(DATA_W - 1);
    localparam logic [BIT_W-1:0] MID_SLOT  = BIT_W'(DATA_W / 2);

    logic [BIT_W-1:0]  slot;
    logic [DATA_W-1:0] sample;
    logic [DATA_W-1:0] shreg;

    assign frame_end = bit_fall && (slot == LAST_SLOT);
    assign coil_clk  = (slot < MID_SLOT);
    assign adc_clk   = ~coil_clk;
    assign ser_data  = shreg[DATA_W-1];

    // Advance the slot at each bit fall and wrap it at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot <= '0;
        else if (bit_fall)
            slot <= frame_end ? '0 : slot + BIT_W'(1);
    end

    // Capture the ADC value on the fall that makes the ADC clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sample <= '0;
        else if (bit_fall && (slot == MID_SLOT - BIT_W'(1)))
            sample <= adc_data;
    end

    // Load the captured sample at a frame boundary, otherwise shift left one bit per fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            frame <= 1'b0;
        end else if (frame_end) begin
            shreg <= sample;
            frame <= 1'b1;
        end else if (bit_fall) begin
            shreg <= {shreg[DATA_W-2:0], 1'b0};
        end
    end

    // R5: serial data moves only together with a bit-clock fall.
    p_ser_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(ser_data) |-> $fell(bit_clk));

    // R2: the coil clock changes only at a bit-slot boundary.
    p_coil_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(coil_clk) |-> $fell(bit_clk));

    // R4: once frames start, frame stays high until the next reset.
    p_frame_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame |=> frame);

endmodule

// File: rtl/lf_clock_serializer.sv
// Module: lf_clock_serializer (top)
// Derives bit, coil and ADC clocks from one divider chain and serializes one
// ADC sample per coil period. The unused power and enable outputs are held low.
// Assumes one main clock and a synchronous active-low reset.
module lf_clock_serializer
    import lfr_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIXED_BASE = 11,
    parameter int DIV_W      = 8,
    parameter int DIV_MIN    = 16,
    parameter int DIV_MAX    = 255,
    parameter int DIV_SHIFT  = 3,
    parameter int EN_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_sel,
    input  logic              prog_en,
    input  logic [DIV_W-1:0]  prog_div,
    input  logic [DATA_W-1:0] adc_data,
    output logic              bit_clk,
    output logic              coil_clk,
    output logic              adc_clk,
    output logic              debug_clk,
    output logic              frame,
    output logic              ser_data,
    output logic              hf_pwr,
    output logic [EN_W-1:0]   pwr_en
);
    localparam int HALF_MAX = imax(FIXED_BASE + 1, (DIV_MAX + 1) >> DIV_SHIFT);
    localparam int HALF_W   = $clog2(HALF_MAX + 1);
    localparam int BIT_W    = $clog2(DATA_W);

    logic [HALF_W-1:0] half;
    logic              bit_fall;
    logic              frame_end;

    lfr_rate_sel #(
        .FIXED_BASE (FIXED_BASE),
        .DIV_W      (DIV_W),
        .DIV_MIN    (DIV_MIN),
        .DIV_MAX    (DIV_MAX),
        .DIV_SHIFT  (DIV_SHIFT),
        .HALF_W     (HALF_W)
    ) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .rate_sel  (rate_sel),
        .prog_en   (prog_en),
        .prog_div  (prog_div),
        .half      (half)
    );

    lfr_bit_divider #(
        .HALF_W (HALF_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .half     (half),
        .bit_clk  (bit_clk),
        .bit_fall (bit_fall)
    );

    lfr_frame_seq #(
        .DATA_W (DATA_W),
        .BIT_W  (BIT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_fall  (bit_fall),
        .bit_clk   (bit_clk),
        .adc_data  (adc_data),
        .frame_end (frame_end),
        .coil_clk  (coil_clk),
        .adc_clk   (adc_clk),
        .frame     (frame),
        .ser_data  (ser_data)
    );

    assign debug_clk = adc_clk;
    assign hf_pwr    = 1'b0;
    assign pwr_en    = '0;

endmodule

// File: tb/test_lf_clock_serializer.sv
module test_lf_clock_serializer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_sel = 1'b1;
    logic       prog_en = 1'b0;
    logic [7:0] prog_div = 8'd95;
    logic [7:0] adc_data = 8'h00;
    logic       bit_clk, coil_clk, adc_clk, debug_clk, frame, ser_data, hf_pwr;
    logic [3:0] pwr_en;

    int n_chk = 0;
    int n_bad = 0;

    // Reference state, computed from edge counts.
    int   n_edges = 0;
    int   base = 0;
    int   hcur = 12;
    bit   framed = 0;
    logic [7:0] cap = 8'h00;
    logic [7:0] tx = 8'h00;
    string clk_tag = "R1";

    lf_clock_serializer i_lf_clock_serializer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_sel  (rate_sel),
        .prog_en   (prog_en),
        .prog_div  (prog_div),
        .adc_data  (adc_data),
        .bit_clk   (bit_clk),
        .coil_clk  (coil_clk),
        .adc_clk   (adc_clk),
        .debug_clk (debug_clk),
        .frame     (frame),
        .ser_data  (ser_data),
        .hf_pwr    (hf_pwr),
        .pwr_en    (pwr_en)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Half period from R1 and R7.
    function automatic int exp_half();
        int d;
        if (!prog_en) return 11 + int'(rate_sel);
        d = int'(prog_div);
        if (d < 16) d = 16;
        return (d + 1) >> 3;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", tag, what, act, expv, n_edges);
        end
    endtask

    // One clock: wait for the falling edge, update the reference, compare, then set inputs.
    task automatic step();
        int rel, b, eb;
        bit was_rst;
        @(negedge clk);
        was_rst = !rst_n;
        if (was_rst) begin
            n_edges = 0; base = 0; hcur = exp_half();
            framed = 0; cap = 8'h00; tx = 8'h00;
        end else begin
            n_edges++;
            rel = n_edges - base;
            if (rel == 16 * hcur) begin
                base = n_edges; rel = 0; hcur = exp_half();
                framed = 1; tx = cap;
            end
            if (rel == 8 * hcur) cap = adc_data;
        end
        rel = n_edges - base;
        b = rel / (2 * hcur);
        eb = framed ? int'(tx[7 - b]) : 0;
        if (was_rst) begin
            chk("R9", "bit_clk", int'(bit_clk), 0);
            chk("R9", "coil_clk", int'(coil_clk), 1);
            chk("R9", "adc_clk", int'(adc_clk), 0);
            chk("R9", "frame", int'(frame), 0);
            chk("R9", "ser_data", int'(ser_data), 0);
        end else begin
            chk(clk_tag, "bit_clk", int'(bit_clk), (rel / hcur) % 2);
            chk("R2", "coil_clk", int'(coil_clk), (b < 4) ? 1 : 0);
            chk("R3", "adc_clk", int'(adc_clk), (b >= 4) ? 1 : 0);
            chk("R3", "debug_clk", int'(debug_clk), int'(adc_clk));
            chk("R4", "frame", int'(frame), int'(framed));
            chk("R5", "ser_data", int'(ser_data), eb);
        end
        chk("R6", "hf_pwr/pwr_en", int'({hf_pwr, pwr_en}), 0);
    endtask

    task automatic run(input int cycles, input int data_every, input int rate_every);
        for (int c = 0; c < cycles; c++) begin
            step();
            if (data_every > 0 && (c % data_every) == data_every - 1)
                adc_data = adc_data * 8'd5 + 8'd53;
            if (rate_every > 0 && (c % rate_every) == rate_every - 1)
                rate_sel = ~rate_sel;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: fixed 125 kHz rate, 4 frames with changing samples.
        clk_tag = "R1";
        rate_sel = 1'b1; prog_en = 1'b0; adc_data = 8'hA5;
        do_reset();
        run(16 * 12 * 4 + 5, 97, 0);

        // R1: fixed 136 kHz rate after reset.
        rate_sel = 1'b0; adc_data = 8'h3C;
        do_reset();
        run(16 * 11 * 4 + 5, 89, 0);

        // R9: reset in mid-run and restart.
        run(50, 0, 0);
        do_reset();
        run(40, 0, 0);

        // R8: toggle the select in mid-frame; it must act only at boundaries.
        clk_tag = "R8";
        run(2500, 71, 61);

        // R7: sweep the programmable divisor, including clamped and edge values.
        clk_tag = "R7";
        prog_en = 1'b1; prog_div = 8'd0;
        do_reset();
        run(200, 37, 0);
        for (int v = 0; v < 256; v += 7) begin
            prog_div = 8'(v);
            run(300, 41, 0);
        end
        prog_div = 8'd255;
        run(600, 43, 0);
        prog_div = 8'd95;
        run(450, 43, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule